// File: doc/BRIEF.md
# Memory-mapped match timer

This block is a 32-bit one-shot match timer that sits on a simple single-cycle register bus. Software writes a target value to the match register. That write arms the timer. The timer then counts up from the present counter value toward the target, advancing by one on each cycle in which the tick-enable input is high. The tick enable is expected to come from a prescaler that divides the system clock down to a nominal 50 MHz tick.

When the remaining distance runs out, the following happens:
- The counter settles on the match value.
- The timer stops.
- If the interrupt-enable register holds any nonzero value, a status flag is set and the level interrupt output goes high.

Software acknowledges the flag by writing zero to the status register. The timer stays idle until the match register is written again.

The counter value that software reads is always the match value minus the remaining distance. There is no separate counting register.

Arming computes the new distance in one of two ways:
- If the target is above the present count, the distance is the target minus the count.
- Otherwise the count has to wrap around past the all-ones value, and the distance is the target plus the all-ones value minus the count.

Top module: `match_timer`

## Requirements
- R1: After reset, the counter, status and interrupt-enable registers all read as zero, and `irq` is low.
- R2: The register word offsets are: 0x00 match (write only), 0x10 counter (read only), 0x14 status (read/write, bit 0 only), 0x1C interrupt enable (read/write, all 32 bits). The read data for an access presented in cycle N appears on `rdata` after the clock edge that ends cycle N.
- R3: A match write with value M arms the timer from the live count C. If M > C, the remaining distance is M - C; otherwise it is M + (0xFFFFFFFF - C). The counter reads M minus the remaining distance, modulo 2^32.
- R4: While the timer is armed, the remaining distance drops by one on each clock edge at which `tick` is high. With `tick` low the counter does not change.
- R5: On the tick at which the remaining distance reaches zero, the counter becomes equal to M and the timer stops. Any later ticks leave the counter unchanged until the next match write.
- R6: On that final tick, a nonzero interrupt-enable value sets status to 1. With the enable at zero, the status stays 0 and `irq` stays low.
- R7: A zero written to status clears it. A nonzero write to status changes nothing and pulses `err`. If a hit and a clearing write fall on the same edge, the hit wins.
- R8: Each of the following pulses `err` for one cycle after the access, returns zero read data, and changes no register: an access to an offset outside the map, a misaligned offset, a read of the match offset, or a write to the counter offset.
- R9: A match write while the timer is armed re-arms it from the live count. A match write never clears a pending status flag.
- R10: `irq` is a level that is high exactly while the status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| req | input | 1 | Bus access valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW (8) | Byte offset of the access |
| wdata | input | W (32) | Write data |
| rdata | output | W (32) | Registered read data |
| err | output | 1 | Registered access-error pulse |
| irq | output | 1 | Level interrupt |

## Verification
Every result of this block is registered, so each one is due exactly one clock edge after its cause:
- read data and the error pulse follow the edge that accepts the access;
- the counter and status follow the edge carrying the last needed tick;
- `irq` changes on the same edge as status.

The bench therefore drives inputs on falling edges and samples on the falling edge after the single rising edge that consumed them. The counter is read only while `tick` is held low, so each expected count is fixed by the number of tick cycles applied.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          err,
  output logic          irq
);
  localparam logic [AW-1:0] OFF_MATCH = AW'(8'h00);
  localparam logic [AW-1:0] OFF_COUNT = AW'(8'h10);
  localparam logic [AW-1:0] OFF_STAT  = AW'(8'h14);
  localparam logic [AW-1:0] OFF_IEN   = AW'(8'h1C);
  localparam logic [W-1:0]  ALL_ONES  = {W{1'b1}};

  logic [W-1:0] match_q, remain_q, ien_q;
  logic         running_q, status_q;

  wire [W-1:0] count_now = match_q - remain_q;

  wire sel_match = addr == OFF_MATCH;
  wire sel_count = addr == OFF_COUNT;
  wire sel_stat  = addr == OFF_STAT;
  wire sel_ien   = addr == OFF_IEN;

  wire wr = req & we;
  wire rd = req & ~we;

  wire wr_match    = wr & sel_match;
  wire wr_ien      = wr & sel_ien;
  wire wr_stat_ok  = wr & sel_stat & (wdata == '0);
  wire wr_stat_bad = wr & sel_stat & (wdata != '0);

  wire legal_wr = sel_match | sel_stat | sel_ien;
  wire legal_rd = sel_count | sel_stat | sel_ien;
  wire bad      = (wr & ~legal_wr) | (rd & ~legal_rd) | wr_stat_bad;

  wire [W-1:0] arm_dist = (wdata > count_now) ? (wdata - count_now)
                                              : (wdata + (ALL_ONES - count_now));

  wire step = running_q & tick & ~wr_match;
  wire hit  = step & (remain_q <= W'(1));

  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd) begin
      if (sel_count)     rd_mux = count_now;
      else if (sel_stat) rd_mux = {{(W-1){1'b0}}, status_q};
      else if (sel_ien)  rd_mux = ien_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q   <= '0;
      remain_q  <= '0;
      running_q <= 1'b0;
    end else if (wr_match) begin
      match_q   <= wdata;
      remain_q  <= arm_dist;
      running_q <= 1'b1;
    end else if (step) begin
      remain_q  <= (remain_q == '0) ? '0 : remain_q - W'(1);
      if (hit) running_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (wr_ien) ien_q <= wdata;
      if (hit && ien_q != '0) status_q <= 1'b1;
      else if (wr_stat_ok)    status_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= rd_mux;
      err   <= bad;
    end
  end

  assign irq = status_q;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          req,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  rdata,
  input logic          err,
  input logic          irq,
  input logic [W-1:0]  remain_q,
  input logic          running_q,
  input logic [W-1:0]  ien_q
);
  wire mapped = (addr == AW'(8'h00)) || (addr == AW'(8'h10)) ||
                (addr == AW'(8'h14)) || (addr == AW'(8'h1C));
  wire match_wr = req && we && (addr == AW'(8'h00));

  a_r8_unmapped_err: assert property (@(posedge clk) disable iff (!rst_n)
    req && !mapped |=> err);

  a_r8_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rdata == '0);

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ien_q) != '0);

  a_r7_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && addr == AW'(8'h14) && wdata == '0 && !tick |=> !irq);

  a_r4_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !match_wr |=> $stable(remain_q));

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q && !match_wr |=> $stable(remain_q) && !running_q);
endmodule

bind match_timer match_timer_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .we(we), .addr(addr),
  .wdata(wdata), .rdata(rdata), .err(err), .irq(irq),
  .remain_q(remain_q), .running_q(running_q), .ien_q(ien_q)
);

// File: tb/match_timer_test.sv
module match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        irq;

  int checks = 0;
  int errors = 0;

  match_timer uut (.clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .we(we),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .err(err), .irq(irq));

  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] match;
    logic [15:0] ticks;
    logic [31:0] exp_count;
    logic        exp_stat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'd10, 16'd4,  32'd4,  1'b0},
    '{32'd10, 16'd6,  32'd10, 1'b1},
    '{32'd5,  16'd3,  32'd14, 1'b0},
    '{32'd20, 16'd10, 32'd20, 1'b1},
    '{32'd20, 16'd0,  32'd21, 1'b0},
    '{32'h30, 16'h1B, 32'h30, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    e = err;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata; e = err;
    req = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    bus_rd(8'h10, d, e); chk("R1 counter", d, 32'd0);
    bus_rd(8'h14, d, e); chk("R1 status", d, 32'd0);
    bus_rd(8'h1C, d, e); chk("R1 enable", d, 32'd0);

    // R2 enable register holds all bits
    bus_wr(8'h1C, 32'hA5A5_0F0F, e); chk("R2 enable write err", {31'b0, e}, 32'd0);
    bus_rd(8'h1C, d, e); chk("R2 enable readback", d, 32'hA5A5_0F0F);
    bus_wr(8'h1C, 32'd1, e);

    // R3 R4 R5 R6 vector walk
    foreach (VECS[i]) begin
      bus_wr(8'h00, VECS[i].match, e);
      if (VECS[i].ticks != 0) ticks(int'(VECS[i].ticks));
      bus_rd(8'h10, d, e); chk($sformatf("R3/R4/R5 vec%0d counter", i), d, VECS[i].exp_count);
      bus_rd(8'h14, d, e); chk($sformatf("R6 vec%0d status", i), d, {31'b0, VECS[i].exp_stat});
      bus_wr(8'h14, 32'd0, e);
    end

    // R10 R6 irq level on hit
    bus_wr(8'h00, 32'h32, e);
    ticks(2);
    chk("R10 irq high on hit", {31'b0, irq}, 32'd1);

    // R7 nonzero status write ignored with error
    bus_wr(8'h14, 32'd5, e); chk("R7 nonzero write err", {31'b0, e}, 32'd1);
    bus_rd(8'h14, d, e);     chk("R7 status kept", d, 32'd1);

    // R9 re-arm keeps status and restarts from live count
    bus_wr(8'h00, 32'h40, e);
    bus_rd(8'h14, d, e);     chk("R9 status kept on arm", d, 32'd1);
    ticks(3);
    bus_rd(8'h10, d, e);     chk("R9 counter mid run", d, 32'h35);
    bus_wr(8'h00, 32'h38, e);
    ticks(3);
    bus_rd(8'h10, d, e);     chk("R9 re-armed hit", d, 32'h38);

    // R7 zero write clears
    bus_wr(8'h14, 32'd0, e); chk("R7 clear err", {31'b0, e}, 32'd0);
    chk("R10 irq low after clear", {31'b0, irq}, 32'd0);
    bus_rd(8'h14, d, e);     chk("R7 status cleared", d, 32'd0);
    bus_wr(8'h14, 32'd0, e); chk("R7 clear when idle err", {31'b0, e}, 32'd0);

    // R6 disabled interrupt
    bus_wr(8'h1C, 32'd0, e);
    bus_wr(8'h00, 32'h3A, e);
    ticks(2);
    chk("R6 irq stays low", {31'b0, irq}, 32'd0);
    bus_rd(8'h14, d, e);     chk("R6 status stays 0", d, 32'd0);
    bus_rd(8'h10, d, e);     chk("R5 counter at match", d, 32'h3A);
    ticks(4);
    bus_rd(8'h10, d, e);     chk("R5 stopped after hit", d, 32'h3A);

    // R8 illegal accesses
    bus_rd(8'h04, d, e);     chk("R8 unmapped read err", {31'b0, e}, 32'd1);
                             chk("R8 unmapped read data", d, 32'd0);
    bus_rd(8'h00, d, e);     chk("R8 match read err", {31'b0, e}, 32'd1);
                             chk("R8 match read data", d, 32'd0);
    bus_wr(8'h08, 32'h1234, e); chk("R8 unmapped write err", {31'b0, e}, 32'd1);
    bus_wr(8'h10, 32'd0, e); chk("R8 counter write err", {31'b0, e}, 32'd1);
    bus_rd(8'h10, d, e);     chk("R8 counter unchanged", d, 32'h3A);
    bus_wr(8'h1D, 32'hFF, e); chk("R8 misaligned err", {31'b0, e}, 32'd1);
    bus_rd(8'h1C, d, e);     chk("R8 enable unchanged", d, 32'd0);
    chk("R2 err single pulse", {31'b0, err}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule